// File: doc/BRIEF.md
# Receive Link Error Collector and Interrupt Unit

This block gathers error events from sixteen receive links into four sixteen-bit error registers, one bit per channel in each: a link-error register, a threshold register, a data-recovery (DRU) range register and a cell-clock register. A link error is an IDLE word whose masked bit pattern does not match. Every eighth link error on a channel also sets that channel's threshold bit. A cell-clock error is an IDLE word in the last word of a cell period whose two flag bits are not both high. The DRU range event arrives already detected.

A control register holds a resync enable and an interrupt enable for each of the four error classes. The block drives an active-low interrupt, counting only channels whose output is enabled. It also drives one resync request per channel. A byte-wide port with synchronous read and write strobes returns the error registers, a summary status byte and the control byte. Reading an error byte clears it. When a link reinitialises, that channel's error state is cleared.

Top module: `errirq_unit`

## Requirements
- R1: When `rx_idle[ch]` and `rx_bad[ch]` are both high at a clock edge, link-error bit `ch` (class index 0) is set at that edge.
- R2: Each channel counts its link errors in a 3-bit counter that wraps from 7 to 0. The link error that wraps the counter (the 8th, 16th and so on) also sets threshold bit `ch` (class index 1).
- R3: When `rx_idle[ch]` and `cell_last[ch]` are high and `rx_bflag[2*ch+1:2*ch]` is not 2'b11, cell-clock bit `ch` (class index 3) is set.
- R4: When `dru_oor[ch]` is high, DRU bit `ch` (class index 2) is set.
- R5: The control byte is at address 0x01 and can be read and written. Bits 7..4 are resync enables and bits 3..0 are interrupt enables. Both nibbles are ordered cell, DRU, threshold, link from the high bit to the low bit. It resets to 0x00.
- R6: The status byte is at address 0x00 and is read-only. Bits 3..0 are high when any bit is set in the cell, DRU, threshold or link register respectively. Bits 7..4 read 0.
- R7: `irq_n` is low exactly when, for some class with its interrupt enable set, an error bit is set on a channel whose `out_en` bit is high.
- R8: `resync_req[ch]` is high exactly when channel `ch` has an error bit set in a class whose resync enable is set.
- R9: The error registers are read at these addresses, low byte first: cell at 0x04/0x05, DRU at 0x06/0x07, threshold at 0x08/0x09, link at 0x0A/0x0B. Bit n of the low byte is channel n and bit n of the high byte is channel n+8. Address bit 5 is ignored and unmapped addresses read 0. `cpu_rdata` holds the value from the clock edge that sampled `cpu_rd` high. That read clears the byte it returned.
- R10: An error event that occurs in the same cycle as a clearing read of its byte still sets its bit.
- R11: When `relink[ch]` is high, channel `ch`'s four error bits and its counter are cleared. This overrides events in the same cycle.
- R12: While `rst_n` is low, all registers, counters and `cpu_rdata` are 0. `irq_n` is high and `resync_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_idle | input | 16 | Received word on each channel is an IDLE |
| rx_bad | input | 16 | IDLE bit-pattern check failed on each channel |
| rx_bflag | input | 32 | Two flag bits of the received word, two per channel |
| cell_last | input | 16 | Current word is the last of the cell period |
| dru_oor | input | 16 | Data recovery out of range on each channel |
| relink | input | 16 | Channel is being reinitialised |
| out_en | input | 16 | Output enable per channel, gates the interrupt |
| cpu_addr | input | 6 | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt |
| resync_req | output | 16 | Per-channel resync request |

## Verification
Random traffic mixes sparse link, cell and DRU events, occasional relinks, output-enable changes, control writes and reads at all 64 addresses. Together these separate class masking from channel gating, and show that address bit 5 is ignored. Directed sequences drive exactly eight link errors on one channel, which separates the 8th-error threshold from an off-by-one count. They place a read strobe and an event on the same byte in one cycle to show that the set wins. They also pair a relink with an event to show that the clear takes priority. Cell events are sent both with flag bits 2'b11 and with other values, to check that only the wrong flag pattern raises an error.

// File: rtl/errirq_pkg.sv
package errirq_pkg;
    localparam int NCH    = 16;
    localparam int NCLS   = 4;
    localparam int ADDR_W = 6;
    localparam int BYTE_W = 8;

    // class indices; order matches control and status bit order
    localparam int C_LINK = 0;
    localparam int C_THR  = 1;
    localparam int C_DRU  = 2;
    localparam int C_CELL = 3;

    localparam logic [4:0] A_STATUS = 5'h00;
    localparam logic [4:0] A_CTRL   = 5'h01;
    localparam logic [4:0] A_CELL   = 5'h04;
    localparam logic [4:0] A_DRU    = 5'h06;
    localparam logic [4:0] A_THR    = 5'h08;
    localparam logic [4:0] A_LINK   = 5'h0A;

    typedef logic [NCLS-1:0][NCH-1:0] cls_vec_t;
endpackage

// File: rtl/errirq_lane.sv
module errirq_lane
    import errirq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            link_ev,
    input  logic            cell_ev,
    input  logic            dru_ev,
    input  logic            relink,
    input  logic [NCLS-1:0] clr,
    output logic [NCLS-1:0] err
);
    typedef struct packed {
        logic [NCLS-1:0]  err;
        logic [CNT_W-1:0] cnt;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        logic [NCLS-1:0] set_v;
        st_d          = st_q;
        set_v         = '0;
        set_v[C_LINK] = link_ev;
        set_v[C_DRU]  = dru_ev;
        set_v[C_CELL] = cell_ev;
        if (link_ev) begin
            st_d.cnt     = st_q.cnt + 1'b1;
            set_v[C_THR] = (st_q.cnt == '1);
        end
        // set after clear: an event is never lost to a read
        st_d.err = (st_q.err & ~clr) | set_v;
        if (relink) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err = st_q.err;
endmodule

// File: rtl/errirq_port.sv
module errirq_port
    import errirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wdata,
    input  cls_vec_t          err_cls,
    output cls_vec_t          clr_cls,
    output logic [BYTE_W-1:0] ctrl,
    output logic [BYTE_W-1:0] rdata
);
    localparam int HALVES = NCH / BYTE_W;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] rdata;
    } port_t;

    port_t st_d, st_q;
    logic [4:0] a5;
    logic [BYTE_W-1:0] sel;

    assign a5 = addr[4:0];

    always_comb begin
        logic [4:0] base;
        st_d    = st_q;
        clr_cls = '0;
        sel     = '0;
        if (a5 == A_STATUS) begin
            for (int c = 0; c < NCLS; c++) sel[c] = |err_cls[c];
        end else if (a5 == A_CTRL) begin
            sel = st_q.ctrl;
        end
        for (int c = 0; c < NCLS; c++) begin
            unique case (c)
                C_CELL:  base = A_CELL;
                C_DRU:   base = A_DRU;
                C_THR:   base = A_THR;
                default: base = A_LINK;
            endcase
            for (int h = 0; h < HALVES; h++) begin
                if (a5 == base + 5'(h)) begin
                    sel = err_cls[c][h*BYTE_W +: BYTE_W];
                    if (rd) clr_cls[c][h*BYTE_W +: BYTE_W] = '1;
                end
            end
        end
        if (rd) st_d.rdata = sel;
        if (wr && a5 == A_CTRL) st_d.ctrl = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl  = st_q.ctrl;
    assign rdata = st_q.rdata;
endmodule

// File: rtl/errirq_unit.sv
module errirq_unit
    import errirq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    rx_idle,
    input  logic [NCH-1:0]    rx_bad,
    input  logic [2*NCH-1:0]  rx_bflag,
    input  logic [NCH-1:0]    cell_last,
    input  logic [NCH-1:0]    dru_oor,
    input  logic [NCH-1:0]    relink,
    input  logic [NCH-1:0]    out_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              irq_n,
    output logic [NCH-1:0]    resync_req
);
    logic [NCH-1:0]    link_ev, cell_ev;
    logic [NCLS-1:0]   lane_err [NCH];
    cls_vec_t          err_cls, clr_cls;
    logic [BYTE_W-1:0] ctrl_q;

    errirq_port u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (cpu_addr),
        .wr     (cpu_wr),
        .rd     (cpu_rd),
        .wdata  (cpu_wdata),
        .err_cls(err_cls),
        .clr_cls(clr_cls),
        .ctrl   (ctrl_q),
        .rdata  (cpu_rdata)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        assign link_ev[ch] = rx_idle[ch] & rx_bad[ch];
        assign cell_ev[ch] = rx_idle[ch] & cell_last[ch] & ~&rx_bflag[2*ch +: 2];

        errirq_lane #(.CNT_W(CNT_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .link_ev(link_ev[ch]),
            .cell_ev(cell_ev[ch]),
            .dru_ev (dru_oor[ch]),
            .relink (relink[ch]),
            .clr    ({clr_cls[3][ch], clr_cls[2][ch], clr_cls[1][ch], clr_cls[0][ch]}),
            .err    (lane_err[ch])
        );
    end

    always_comb begin
        logic any_irq;
        any_irq = 1'b0;
        for (int ch = 0; ch < NCH; ch++) begin
            for (int c = 0; c < NCLS; c++) err_cls[c][ch] = lane_err[ch][c];
            resync_req[ch] = |(lane_err[ch] & ctrl_q[2*NCLS-1:NCLS]);
        end
        for (int c = 0; c < NCLS; c++) begin
            any_irq = any_irq | (ctrl_q[c] & |(err_cls[c] & out_en));
        end
        irq_n = ~any_irq;
    end
endmodule

// File: rtl/errirq_chk.sv
module errirq_chk
    import errirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NCH-1:0]    link_ev,
    input logic [NCH-1:0]    cell_ev,
    input logic [NCH-1:0]    dru_ev,
    input logic [NCH-1:0]    relink,
    input logic [NCH-1:0]    lerr,
    input logic [NCH-1:0]    cerr,
    input logic [NCH-1:0]    derr,
    input logic [BYTE_W-1:0] ctrl,
    input logic              irq_n,
    input logic [NCH-1:0]    resync_req
);
    // R1 and R10: a link event sets its bit even against a clearing read
    a_r1_link_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_ev & ~relink) != '0) |=> ((lerr & $past(link_ev & ~relink)) == $past(link_ev & ~relink)));

    a_r3_cell_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((cell_ev & ~relink) != '0) |=> ((cerr & $past(cell_ev & ~relink)) == $past(cell_ev & ~relink)));

    a_r4_dru_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((dru_ev & ~relink) != '0) |=> ((derr & $past(dru_ev & ~relink)) == $past(dru_ev & ~relink)));

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (ctrl[NCLS-1:0] != '0));

    a_r8_resync_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_req != '0) |-> (ctrl[2*NCLS-1:NCLS] != '0));

    a_r11_relink_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (relink != '0) |=> ((resync_req & $past(relink)) == '0));
endmodule

bind errirq_unit errirq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_ev   (link_ev),
    .cell_ev   (cell_ev),
    .dru_ev    (dru_oor),
    .relink    (relink),
    .lerr      (err_cls[0]),
    .cerr      (err_cls[3]),
    .derr      (err_cls[2]),
    .ctrl      (ctrl_q),
    .irq_n     (irq_n),
    .resync_req(resync_req)
);

// File: tb/errirq_unit_test.sv
`timescale 1ns/1ps
module errirq_unit_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] rx_idle = 0, rx_bad = 0, cell_last = 0, dru_oor = 0, relink = 0, out_en = 0;
    logic [31:0] rx_bflag = 0;
    logic [5:0]  cpu_addr = 0;
    logic        cpu_wr = 0, cpu_rd = 0;
    logic [7:0]  cpu_wdata = 0;
    logic [7:0]  cpu_rdata;
    logic        irq_n;
    logic [15:0] resync_req;

    int n_run = 0, n_fail = 0;
    logic [15:0] m_err [4];
    int          m_cnt [16];
    logic [7:0]  m_ctrl = 0;
    logic [7:0]  m_rd = 0;

    always #4 clk = ~clk;

    errirq_unit uut (.*);

    function automatic logic [7:0] mread(input logic [5:0] a);
        logic [4:0] x = a[4:0];
        logic [7:0] v = 0;
        if (x == 0) for (int c = 0; c < 4; c++) v[c] = |m_err[c];
        else if (x == 1) v = m_ctrl;
        else if (x >= 4 && x <= 11) begin
            // 4,5 cell; 6,7 dru; 8,9 thr; 10,11 link
            int c = 3 - int'((x - 4) / 2);
            v = x[0] ? m_err[c][15:8] : m_err[c][7:0];
        end
        return v;
    endfunction

    function automatic logic exp_irq_n();
        for (int c = 0; c < 4; c++) if (m_ctrl[c] && |(m_err[c] & out_en)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [15:0] exp_resync();
        logic [15:0] r = 0;
        for (int ch = 0; ch < 16; ch++)
            for (int c = 0; c < 4; c++) if (m_ctrl[4+c] && m_err[c][ch]) r[ch] = 1;
        return r;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: model update from requirements, then compare
    task automatic cycle();
        logic [4:0] x = cpu_addr[4:0];
        if (cpu_rd) m_rd = mread(cpu_addr);
        for (int ch = 0; ch < 16; ch++) begin
            logic le = rx_idle[ch] & rx_bad[ch];
            logic ce = rx_idle[ch] & cell_last[ch] & (rx_bflag[2*ch +: 2] != 2'b11);
            logic th = le && m_cnt[ch] == 7;
            if (cpu_rd && x >= 4 && x <= 11 && (ch / 8) == int'(x[0]))
                m_err[3 - int'((x - 4) / 2)][ch] = 0;
            if (le) m_cnt[ch] = (m_cnt[ch] + 1) % 8;
            m_err[0][ch] = m_err[0][ch] | le;
            m_err[1][ch] = m_err[1][ch] | th;
            m_err[2][ch] = m_err[2][ch] | dru_oor[ch];
            m_err[3][ch] = m_err[3][ch] | ce;
            if (relink[ch]) begin
                for (int c = 0; c < 4; c++) m_err[c][ch] = 0;
                m_cnt[ch] = 0;
            end
        end
        if (cpu_wr && x == 1) m_ctrl = cpu_wdata;
        @(posedge clk);
        @(negedge clk);
        check("R7 irq_n", {15'd0, irq_n}, {15'd0, exp_irq_n()});
        check("R8 resync_req", resync_req, exp_resync());
        check("R9 cpu_rdata", {8'd0, cpu_rdata}, {8'd0, m_rd});
    endtask

    task automatic idle_in();
        rx_idle = 0; rx_bad = 0; cell_last = 0; dru_oor = 0; relink = 0;
        cpu_wr = 0; cpu_rd = 0; rx_bflag = '1;
    endtask

    task automatic rd(input logic [5:0] a);
        idle_in(); cpu_rd = 1; cpu_addr = a; cycle(); cpu_rd = 0;
    endtask

    task automatic wrc(input logic [7:0] d);
        idle_in(); cpu_wr = 1; cpu_addr = 6'h01; cpu_wdata = d; cycle(); cpu_wr = 0;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5eed1));
        for (int c = 0; c < 4; c++) m_err[c] = 0;
        for (int ch = 0; ch < 16; ch++) m_cnt[ch] = 0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 irq_n in reset", {15'd0, irq_n}, 16'd1);
        check("R12 resync in reset", resync_req, 16'd0);
        check("R12 rdata in reset", {8'd0, cpu_rdata}, 16'd0);
        rst_n = 1;
        out_en = 16'hFFFF;
        rd(6'h00);
        check("R6 status after reset", {8'd0, cpu_rdata}, 16'd0);
        // R5 control readback, bit 5 of address ignored
        wrc(8'hFF);
        rd(6'h21);
        check("R5 ctrl readback", {8'd0, cpu_rdata}, 16'h00FF);
        // R2 eight link errors on channel 3
        for (int i = 0; i < 7; i++) begin
            idle_in(); rx_idle[3] = 1; rx_bad[3] = 1; cycle();
        end
        rd(6'h08);
        check("R2 no threshold after 7", {8'd0, cpu_rdata}, 16'h0000);
        idle_in(); rx_idle[3] = 1; rx_bad[3] = 1; cycle();
        rd(6'h08);
        check("R2 threshold on 8th", {8'd0, cpu_rdata}, 16'h0008);
        rd(6'h08);
        check("R9 cleared by read", {8'd0, cpu_rdata}, 16'h0000);
        rd(6'h0A);
        check("R1 link bit ch3", {8'd0, cpu_rdata}, 16'h0008);
        // R3 cell error only with flags not 11
        idle_in(); rx_idle[9] = 1; cell_last[9] = 1; rx_bflag[19:18] = 2'b11; cycle();
        rd(6'h05);
        check("R3 flags 11 no error", {8'd0, cpu_rdata}, 16'h0000);
        idle_in(); rx_idle[9] = 1; cell_last[9] = 1; rx_bflag[19:18] = 2'b01; cycle();
        rd(6'h05);
        check("R3 cell error ch9", {8'd0, cpu_rdata}, 16'h0002);
        // R10 set wins over same-cycle read clear
        idle_in(); dru_oor[2] = 1; cycle();
        idle_in(); dru_oor[2] = 1; cpu_rd = 1; cpu_addr = 6'h06; cycle();
        check("R4 dru read", {8'd0, cpu_rdata}, 16'h0004);
        rd(6'h06);
        check("R10 set beats clear", {8'd0, cpu_rdata}, 16'h0004);
        // R11 relink overrides event
        idle_in(); dru_oor[5] = 1; cycle();
        idle_in(); dru_oor[5] = 1; relink[5] = 1; cycle();
        check("R11 resync cleared", resync_req, 16'h0000);
        rd(6'h06);
        check("R11 dru cleared", {8'd0, cpu_rdata}, 16'h0000);
        // R7 out_en gating
        wrc(8'h04);
        idle_in(); dru_oor[1] = 1; out_en = 16'hFFFD; cycle();
        check("R7 masked channel", {15'd0, irq_n}, 16'd1);
        out_en = 16'hFFFF; idle_in(); cycle();
        check("R7 enabled channel", {15'd0, irq_n}, 16'd0);
        rd(6'h00);
        check("R6 status dru", {8'd0, cpu_rdata}, 16'h0004);
        rd(6'h06);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            idle_in();
            rx_idle  = 16'($urandom);
            rx_bad   = 16'($urandom) & 16'($urandom);
            rx_bflag = $urandom;
            cell_last = 16'($urandom) & 16'($urandom);
            dru_oor  = 16'($urandom) & 16'($urandom) & 16'($urandom);
            relink   = ($urandom % 8 == 0) ? 16'($urandom) & 16'($urandom) & 16'($urandom) : 16'h0;
            if ($urandom % 16 == 0) out_en = 16'($urandom);
            if ($urandom % 12 == 0) begin cpu_wr = 1; cpu_wdata = 8'($urandom); end
            cpu_rd = ($urandom % 2 == 0);
            cpu_addr = ($urandom % 3 == 0) ? 6'($urandom) : 6'(4 + $urandom % 8);
            if (cpu_wr) cpu_addr = 6'h01;
            cycle();
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule